// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

A synthesizable single-port synchronous SRAM with a registered read path. It is built from 32-bit words split into four byte lanes. Address, control and write data are taken in on the rising clock edge. A read address captured at one edge reaches the registered output after the following edge. The bidirectional data bus is split into an input word, an output word and a drive flag. The drive flag is gated by an asynchronous, active-low output enable.

An access starts when one of two address strobes is low. The processor strobe counts only while the first select is active. The controller strobe always counts. After an access starts, a burst counter block supplies the two low address bits. Each cycle with the advance input low steps it in linear or interleaved order, and it holds while advance is high. Writes happen either through a global write that fills every lane, or through a byte-write enable with one select per lane. Write data is committed on the edge where the write command is sampled.

Top module: `sync_burst_sram`

## Requirements
- R1: A read sampled at edge k drives that word on `rdata_o` with `drive_o` high after edge k+1, as long as `out_en_n` is low.
- R2: An access edge starts a read when a strobe is low, `sel1_n` and `sel3_n` are low, `sel2` is high, and `wr_all_n` and `lane_wr_en_n` are both high. The lane selects have no effect during such a read.
- R3: With `wr_all_n` low, all four lanes of the word are written, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R4: With `wr_all_n` high and `lane_wr_en_n` low, lane b (bits 8b+7..8b) is written only if `lane_sel_n[b]` is low. The other lanes keep their contents.
- R5: `proc_strobe_n` low is ignored while `sel1_n` is high. With `ctrl_strobe_n` high, a deselected device stays deselected and writes nothing.
- R6: An access edge with any select inactive deselects the device. From the next cycle `drive_o` is low, and no write takes place at that edge.
- R7: In the first cycle after an access that moves the device from deselected to selected, `drive_o` is low even with `out_en_n` low. An access made while already selected keeps the bus driven.
- R8: `out_en_n` high forces `drive_o` low at once, without waiting for a clock edge. Setting it low again restores driving of valid data.
- R9: With `burst_interleave` low, each cycle with `burst_adv_n` low and no strobe moves to the next word in linear order (start+n mod 4) within the aligned group of four.
- R10: With `burst_interleave` high, the burst order is start XOR n.
- R11: A cycle with no strobe and `burst_adv_n` high repeats the current burst word.
- R12: A read of an address in the cycle after it was written returns the new data.
- R13: After synchronous reset `rst`, the device is deselected and `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW (8) | Word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES (4) | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | 32 | Data bus, inbound half |
| rdata_o | output | 32 | Data bus, outbound half |
| drive_o | output | 1 | Outbound data is driven |

## Verification
A read sampled at edge k becomes visible only after edge k+1. For each read, the bench therefore clocks one extra idle cycle, which repeats the same word, and samples the outputs 2 ns after that second edge. A write lands in the array on its own edge, so a read checker can follow immediately. Burst checks account for the one-cycle lag: after the n-th advance edge, the output shows burst word n-1. The first-cycle tristate check samples right after the access edge. The output-enable checks sample 1 ns after changing `out_en_n`, with no edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    SBS_IDLE  = 2'd0,
    SBS_READ  = 2'd1,
    SBS_WRITE = 2'd2
  } sbs_op_e;

  function automatic logic [1:0] sbs_order(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               adv,
  input  logic               interleave,
  input  logic [BURST_W-1:0] load_low,
  output logic [BURST_W-1:0] cur_low
);
  logic [BURST_W-1:0] start_q, step_q, step_n;

  always_comb begin
    step_n = adv ? step_q + BURST_W'(1) : step_q;
    if (load)
      cur_low = load_low;
    else if (interleave)
      cur_low = start_q ^ step_n;
    else
      cur_low = start_q + step_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      start_q <= load_low;
      step_q  <= '0;
    end else begin
      step_q  <= step_n;
    end
  end

  // R9
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> (step_q == $past(step_q) + BURST_W'(1)));

  // R11
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(step_q) && $stable(start_q)));
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             ren,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (we[b]) mem[waddr][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
    end
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic rd_pend,
  input  logic kill,
  input  logic fresh,
  input  logic out_en_n,
  output logic drive
);
  logic valid_q, first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      valid_q <= rd_pend && !kill;
      first_q <= fresh;
    end
  end

  assign drive = valid_q && !first_q && !out_en_n;

  // R1
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && !kill && !fresh && !out_en_n) |=> (drive || out_en_n));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH   = 256,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2,
  localparam int DW     = LANES * LANE_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_i,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             burst_adv_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  input  logic             burst_interleave,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             drive_o
);
  import sbs_pkg::*;

  logic                proc_ok, access, cs_all, active;
  logic [LANES-1:0]    lane_req, lane_we;
  logic                wr_req;
  sbs_op_e             op;
  logic                sel_q, rd_q;
  logic [AW-1:0]       raddr_q, cur_addr;
  logic [AW-BURST_W-1:0] hi_q, hi;
  logic [BURST_W-1:0]  cur_low;

  assign proc_ok = !proc_strobe_n && !sel1_n;
  assign access  = proc_ok || !ctrl_strobe_n;
  assign cs_all  = !sel1_n && sel2 && !sel3_n;
  assign active  = access ? cs_all : sel_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_req[b] = !wr_all_n || (!lane_wr_en_n && !lane_sel_n[b]);
  end
  assign wr_req = |lane_req;

  always_comb begin
    if (!active)     op = SBS_IDLE;
    else if (wr_req) op = SBS_WRITE;
    else             op = SBS_READ;
  end

  assign lane_we  = (op == SBS_WRITE) ? lane_req : '0;
  assign hi       = access ? addr_i[AW-1:BURST_W] : hi_q;
  assign cur_addr = {hi, cur_low};

  sbs_burst_ctr #(.BURST_W(BURST_W)) i_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (access),
    .adv        (!access && sel_q && !burst_adv_n),
    .interleave (burst_interleave),
    .load_low   (addr_i[BURST_W-1:0]),
    .cur_low    (cur_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      hi_q    <= '0;
      raddr_q <= '0;
    end else begin
      if (access) begin
        sel_q <= cs_all;
        hi_q  <= addr_i[AW-1:BURST_W];
      end
      rd_q    <= (op == SBS_READ);
      raddr_q <= cur_addr;
    end
  end

  sbs_mem_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
    .clk   (clk),
    .we    (lane_we),
    .waddr (cur_addr),
    .wdata (wdata_i),
    .ren   (rd_q),
    .raddr (raddr_q),
    .rdata (rdata_o)
  );

  sbs_out_stage i_out (
    .clk      (clk),
    .rst      (rst),
    .rd_pend  (rd_q),
    .kill     (access && !cs_all),
    .fresh    (access && cs_all && !sel_q),
    .out_en_n (out_en_n),
    .drive    (drive_o)
  );

  // R6
  deselect_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (access && !cs_all) |=> !drive_o);

  // R7
  first_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (access && cs_all && !sel_q) |=> !drive_o);

  // R5
  proc_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_strobe_n && sel1_n && ctrl_strobe_n) |=> $stable(sel_q));
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [AW-1:0] addr_i;
  logic        proc_strobe_n, ctrl_strobe_n, burst_adv_n;
  logic        sel1_n, sel2, sel3_n, wr_all_n, lane_wr_en_n;
  logic [3:0]  lane_sel_n;
  logic        out_en_n, burst_interleave;
  logic [31:0] wdata_i, rdata_o;
  logic        drive_o;

  logic [31:0] ref_mem [DEPTH];
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .burst_adv_n(burst_adv_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .burst_interleave(burst_interleave),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o));

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic gw_n, input logic bwe_n,
                                        input logic [3:0] bs_n);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++)
      if (!gw_n || (!bwe_n && !bs_n[b])) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [1:0] seq_low(input logic [1:0] s, input int n, input logic il);
    return il ? (s ^ 2'(n)) : (s + 2'(n));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; burst_adv_n = 1;
    wr_all_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
  endtask

  task automatic deselect();
    idle(); ctrl_strobe_n = 0; sel2 = 0;
    cycle();
    idle();
  endtask

  task automatic wr_cmd(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic gw_n, input logic bwe_n, input logic [3:0] bs_n);
    idle(); ctrl_strobe_n = 0; addr_i = a; wdata_i = d;
    wr_all_n = gw_n; lane_wr_en_n = bwe_n; lane_sel_n = bs_n;
    cycle();
    ref_mem[a] = merge(ref_mem[a], d, gw_n, bwe_n, bs_n);
    idle();
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string tag);
    idle(); ctrl_strobe_n = 0; addr_i = a;
    cycle();
    idle();
    cycle();
    chk({tag, " drive"}, 32'(drive_o), 32'd1);
    chk({tag, " data"}, rdata_o, ref_mem[a]);
  endtask

  task automatic burst_check(input logic [AW-1:0] a, input logic il, input string tag);
    logic [AW-1:0] base = {a[AW-1:2], 2'b00};
    burst_interleave = il;
    idle(); ctrl_strobe_n = 0; addr_i = a;
    cycle();
    for (int n = 1; n <= 4; n++) begin
      idle(); burst_adv_n = (n == 4);
      cycle();
      chk($sformatf("%s word %0d", tag, n - 1), rdata_o,
          ref_mem[base | AW'(seq_low(a[1:0], n - 1, il))]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    idle(); addr_i = '0; wdata_i = '0; out_en_n = 0; burst_interleave = 0;
    rst = 1;
    repeat (3) cycle();
    rst = 0;
    chk("R13 drive after reset", 32'(drive_o), 32'd0);
    cycle();
    chk("R13 still deselected", 32'(drive_o), 32'd0);

    // R3 global write ignores lane inputs; R12 read right after write
    wr_cmd(8'h10, 32'hA1B2C3D4, 0, 1, 4'hF);
    rd_check(8'h10, "R12 R3 global write");
    // R4 byte lanes 0 and 2
    wr_cmd(8'h10, 32'h11223344, 1, 0, 4'b1010);
    rd_check(8'h10, "R4 lanes 0,2");
    chk("R4 expected merge", ref_mem[8'h10], 32'hA122C344);
    // R2 lane selects without byte write enable do nothing
    wr_cmd(8'h10, 32'hFFFFFFFF, 1, 1, 4'h0);
    rd_check(8'h10, "R2 read no write");

    // R1 latency: first cycle after a fresh access, and the following one
    deselect();
    idle(); ctrl_strobe_n = 0; addr_i = 8'h10;
    cycle();
    chk("R7 first cycle tristate", 32'(drive_o), 32'd0);
    idle();
    cycle();
    chk("R1 data after next edge", rdata_o, ref_mem[8'h10]);
    chk("R1 driven", 32'(drive_o), 32'd1);
    // R7 access while selected keeps driving
    idle(); ctrl_strobe_n = 0; addr_i = 8'h20;
    cycle();
    chk("R7 selected access stays driven", 32'(drive_o), 32'd1);
    idle();
    cycle();
    // R8 asynchronous output enable
    out_en_n = 1; #1;
    chk("R8 oe high", 32'(drive_o), 32'd0);
    out_en_n = 0; #1;
    chk("R8 oe low", 32'(drive_o), 32'd1);

    // R6 deselect stops the bus and blocks writes
    idle(); ctrl_strobe_n = 0; sel2 = 0; addr_i = 8'h10; wr_all_n = 0; wdata_i = 32'hDEADBEEF;
    cycle();
    idle();
    chk("R6 bus off after deselect", 32'(drive_o), 32'd0);
    cycle();
    chk("R6 still off", 32'(drive_o), 32'd0);
    rd_check(8'h10, "R6 write blocked");

    // R5 processor strobe ignored while sel1_n high
    deselect();
    idle(); proc_strobe_n = 0; sel1_n = 1; addr_i = 8'h10; wr_all_n = 0; wdata_i = 32'h0BADF00D;
    cycle();
    idle();
    cycle();
    chk("R5 no drive", 32'(drive_o), 32'd0);
    rd_check(8'h10, "R5 no write");
    // processor strobe accepted when sel1_n low
    idle(); proc_strobe_n = 0; addr_i = 8'h10;
    cycle();
    idle();
    cycle();
    chk("R2 processor strobe read", rdata_o, ref_mem[8'h10]);

    // bursts: fill group 0x40..0x43
    for (int i = 0; i < 4; i++) wr_cmd(8'h40 + 8'(i), 32'hC0DE0000 + 32'(i * 17), 0, 1, 4'hF);
    burst_check(8'h41, 0, "R9 linear");
    burst_check(8'h42, 0, "R9 linear wrap");
    burst_check(8'h41, 1, "R10 interleaved");
    burst_check(8'h43, 1, "R10 interleaved top");
    burst_interleave = 0;

    // R11 suspend repeats the word
    idle(); ctrl_strobe_n = 0; addr_i = 8'h41;
    cycle();
    idle(); burst_adv_n = 0; cycle();
    idle(); cycle();
    chk("R11 suspend 1", rdata_o, ref_mem[8'h42]);
    idle(); cycle();
    chk("R11 suspend 2", rdata_o, ref_mem[8'h42]);
    idle(); burst_adv_n = 0; cycle();
    idle(); cycle();
    chk("R11 resume", rdata_o, ref_mem[8'h43]);

    // random mix: R3 R4 R12
    for (int it = 0; it < 150; it++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 1) == 1) begin
        logic gw = ($urandom_range(0, 3) != 0);
        wr_cmd(a, $urandom, gw, gw ? 1'b0 : 1'b1, 4'($urandom));
        rd_check(a, "R12 R4 random write-read");
      end else begin
        rd_check(a, "R1 random read");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule